// File: doc/BRIEF.md
# Universal Shift Register

A small storage register whose action at every rising clock edge is picked by a two-bit mode code: keep the contents, move every bit one place down, move every bit one place up, or take a new word from the parallel inputs. Each flip-flop has its own selector in front of it. Each shift direction has its own serial input, tied to a fixed end of the register. All contents are visible at once on the parallel outputs. An active-low clear empties the register at once, without waiting for a clock edge.

The register serves as a serial-to-parallel or parallel-to-serial converter. It can be chained into wider registers. To chain two copies, feed the low copy's top serial input from the high copy's bit 0, and feed the high copy's bottom serial input from the low copy's top bit. The width is a parameter with a default of four bits.

Top module: `ushift_reg`

## Requirements
- R1: While `rst_n` is 0, `q` is all zeros at once, with no clock edge needed, whatever `mode` and the data inputs are.
- R2: Mode code 2'b00 keeps `q` unchanged across a rising edge.
- R3: Mode code 2'b11 copies `par_in` into `q` at a rising edge.
- R4: Mode code 2'b10 moves each bit i to bit i-1 at a rising edge. `ser_top` enters bit WIDTH-1 and the old bit 0 is lost.
- R5: Mode code 2'b01 moves each bit i to bit i+1 at a rising edge. `ser_bot` enters bit 0 and the old top bit is lost.
- R6: A serial input has no effect on `q` unless its own shift mode is selected. `ser_top` acts only in 2'b10 and `ser_bot` acts only in 2'b01.
- R7: `q` changes only at a rising clock edge or when clear is asserted. Changing `par_in` or `mode` between edges leaves `q` unchanged.
- R8: Two instances chained through their end bits and serial inputs behave as one register of twice the width, in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Action code: 00 keep, 01 move up, 10 move down, 11 load |
| par_in | input | WIDTH | Parallel load word |
| ser_top | input | 1 | Serial bit entering the top bit in mode 10 |
| ser_bot | input | 1 | Serial bit entering bit 0 in mode 01 |
| q | output | WIDTH | Register contents |

## Verification
Two instances are chained into an eight-bit register. Every one of the 256 starting words is loaded and then put through all four mode codes, with all four combinations of the two external serial bits. This separates the two shift directions and shows which end each serial bit enters. It also exposes a serial input that leaks into hold, load or the other direction, and shows whether a bit crosses correctly between the two halves. Further cases assert clear in the middle of a cycle while a load is selected, and change the parallel word and the mode code between edges.

// File: rtl/ushift_reg.sv
module ushift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_top,
  input  logic             ser_bot,
  output logic [WIDTH-1:0] q
);
  localparam logic [1:0] M_KEEP = 2'b00;
  localparam logic [1:0] M_UP   = 2'b01;
  localparam logic [1:0] M_DOWN = 2'b10;
  localparam logic [1:0] M_LOAD = 2'b11;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic above, below;
    if (i == WIDTH-1) begin : g_top
      assign above = ser_top;
    end else begin : g_mid_a
      assign above = q[i+1];
    end
    if (i == 0) begin : g_bot
      assign below = ser_bot;
    end else begin : g_mid_b
      assign below = q[i-1];
    end
    always_comb begin
      case (mode)
        M_UP:    nxt[i] = below;
        M_DOWN:  nxt[i] = above;
        M_LOAD:  nxt[i] = par_in[i];
        default: nxt[i] = q[i];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

module ushift_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_top,
  input logic             ser_bot,
  input logic [WIDTH-1:0] q
);
  assert_clear_R1: assert property (@(posedge clk) !rst_n |-> q == '0);

  assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> $stable(q));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> q == $past(par_in));

  assert_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> q == {$past(ser_top), $past(q[WIDTH-1:1])});

  assert_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> q == {$past(q[WIDTH-2:0]), $past(ser_bot)});
endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(par_in),
  .ser_top(ser_top), .ser_bot(ser_bot), .q(q)
);

// File: tb/ushift_reg_bench.sv
module ushift_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic [7:0] word;
  logic       ext_top, ext_bot;
  logic [3:0] q_hi, q_lo;
  logic [7:0] q8;
  int         checks = 0;
  int         errors = 0;

  assign q8 = {q_hi, q_lo};

  always #(CLK_PERIOD/2) clk = ~clk;

  ushift_reg #(.WIDTH(4)) u_ushift_reg (
    .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(word[7:4]),
    .ser_top(ext_top), .ser_bot(q_lo[3]), .q(q_hi)
  );

  ushift_reg #(.WIDTH(4)) u_ushift_reg_lo (
    .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(word[3:0]),
    .ser_top(q_hi[0]), .ser_bot(ext_bot), .q(q_lo)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [7:0] d, input logic st, input logic sb);
    @(negedge clk);
    mode = m; word = d; ext_top = st; ext_bot = sb;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b11; word = 8'hA5; ext_top = 1'b1; ext_bot = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset state", q8, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 256; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int sv = 0; sv < 4; sv++) begin
          logic [7:0] exp;
          logic st, sb;
          st = sv[1]; sb = sv[0];
          step(2'b11, 8'(s), ~st, ~sb);
          chk("R3 load", q8, 8'(s));
          step(2'(m), ~8'(s), st, sb);
          case (m)
            0: exp = 8'(s);
            1: exp = {8'(s) << 1} | {7'b0, sb};
            2: exp = {st, 7'(s >> 1)};
            default: exp = ~8'(s);
          endcase
          case (m)
            0: chk("R2 R6 R8 keep", q8, exp);
            1: chk("R5 R6 R8 up", q8, exp);
            2: chk("R4 R6 R8 down", q8, exp);
            default: chk("R3 R6 R8 load", q8, exp);
          endcase
        end
      end
    end

    step(2'b11, 8'h3C, 1'b0, 1'b0);
    @(negedge clk);
    word = 8'hC3; mode = 2'b01;
    #2;
    chk("R7 no change between edges", q8, 8'h3C);
    mode = 2'b11;
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 async clear mid-cycle over load", q8, 8'h00);
    @(posedge clk);
    #1;
    chk("R1 clear held across edge", q8, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b11, 8'h81, 1'b0, 1'b0);
    chk("R3 load after clear", q8, 8'h81);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule